// File: doc/BRIEF.md
# Serial Shift Output Controller

This block feeds a chain of external serial-in, parallel-out shift registers from a 24-bit output word held in a shadow register. The word is split into three 8-bit groups, and each group can be enabled on its own. A transfer sends the enabled groups as serial data with a shift clock, then pulses a store strobe so the external registers move the new bits to their outputs.

A transfer starts when software writes a one-shot command or when a periodic timer expires. The timer has three rates and a prescaler, and it counts system clock cycles. Up to fourteen low-order output bits can be taken over by hardware status inputs: a 2-bit line-status source and four 3-bit port-status sources. The taken-over bits reach the wire in place of the shadow bits. A configuration bit chooses which shift-clock edge the data changes on. Software writes the registers through a simple write strobe, address and data port.

Top module: `sso_ctrl`

## Requirements
- R1: After reset the shadow word is zero, all groups and overrides are disabled, and automatic update is off. `sck_o`, `stb_o`, `busy_o` and `sdo_o` are all low, and no transfer starts until one is requested.
- R2: A write of 1 to bit 0 at address 3 starts one transfer of the shadow word (address 0, bits [23:0]). Groups go out highest enabled group first. Within a group the bits go out from bit 7 down to bit 0.
- R3: Bits [2:0] of the config register (address 1) enable groups 2..0; group g covers word bits [8g+7:8g]. Disabled groups are skipped. A request while no group is enabled starts no transfer.
- R4: The override mask is at address 2, bits [13:0], and lines up with word bits [13:0]. Word bits [1:0] come from `dsl_i`. Bits [4:2], [7:5], [10:8] and [13:11] come from `phy_i[2:0]`, `[5:3]`, `[8:6]` and `[11:9]`. A set mask bit sends the hardware value; a clear mask bit sends the shadow bit.
- R5: Config bits [23:16] hold DIV. Each shift-clock half period lasts DIV+1 system cycles, so one bit takes 2*(DIV+1) cycles.
- R6: After the last bit, `stb_o` is high for exactly one shift-clock period, 2*(DIV+1) cycles, and then the block returns to idle.
- R7: When config bit 3 is 0, `sdo_o` changes only with a falling `sck_o` and the idle level of `sck_o` is low. When bit 3 is 1, `sdo_o` changes with a rising `sck_o` and the idle level is high. In both modes the data is stable at the opposite edge.
- R8: `busy_o` is high during a transfer. A software request made while busy is held and runs right after the current transfer. Each transfer sends the word as it stood when that transfer began.
- R9: Config bit 4 enables automatic update. Bits [6:5] pick the rate: 1 gives a period of 10 units, 2 gives 5 units and 3 gives 4 units; 0 gives no updates. Bits [9:8] are the prescaler P, and one unit is UNIT_CYC << P system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Register write data |
| dsl_i | input | 2 | Line-status override source for word bits 1:0 |
| phy_i | input | 12 | Four 3-bit port-status override sources |
| sdo_o | output | 1 | Serial data |
| sck_o | output | 1 | Shift clock |
| stb_o | output | 1 | Store strobe |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench sweeps every non-empty set of enabled groups over several shadow patterns. A design that sent groups low-first or sent a disabled group would produce a stream of the wrong order or length. Override masks are tried with mixed hardware values, which catches a mask that is shifted off by one source or applied to the wrong bits. Bit period and strobe width are measured for several divider settings. The edge option is checked by sampling on the opposite edge and by counting any data change at that edge. A second request made during a long transfer must produce a second transfer carrying the newer word; a design that dropped it, or merged the two, shows up here. Automatic periods are timed for each rate and two prescaler settings.

// File: rtl/sso_pkg.sv
package sso_pkg;
  localparam int GROUPS = 3;
  localparam int GRP_W  = 8;
  localparam int WORD_W = GROUPS * GRP_W;
  localparam int DSL_W  = 2;
  localparam int PHY_N  = 4;
  localparam int PHY_W  = 3;
  localparam int OVR_W  = DSL_W + PHY_N * PHY_W;
  localparam int DIV_W  = 8;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    A_SHADOW = 2'd0,
    A_CFG    = 2'd1,
    A_OVR    = 2'd2,
    A_CMD    = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SHIFT  = 2'd1,
    S_STROBE = 2'd2
  } sh_state_e;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [1:0]        presc;
    logic [1:0]        rate;
    logic              auto_en;
    logic              rise;
    logic [GROUPS-1:0] grp_en;
  } cfg_t;
endpackage

// File: rtl/sso_regs.sv
module sso_regs
  import sso_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [WORD_W-1:0] shadow_o,
  output cfg_t              cfg_o,
  output logic [OVR_W-1:0]  ovr_o,
  output logic              sw_req_o
);
  reg_addr_e addr;
  logic      unused_wdata;

  assign addr         = reg_addr_e'(addr_i);
  assign unused_wdata = ^wdata_i[31:24];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
      cfg_o    <= '0;
      ovr_o    <= '0;
      sw_req_o <= 1'b0;
    end else begin
      sw_req_o <= we_i && (addr == A_CMD) && wdata_i[0];
      if (we_i) begin
        unique case (addr)
          A_SHADOW: shadow_o <= wdata_i[WORD_W-1:0];
          A_CFG: begin
            cfg_o.grp_en  <= wdata_i[2:0];
            cfg_o.rise    <= wdata_i[3];
            cfg_o.auto_en <= wdata_i[4];
            cfg_o.rate    <= wdata_i[6:5];
            cfg_o.presc   <= wdata_i[9:8];
            cfg_o.div     <= wdata_i[23:16];
          end
          A_OVR:   ovr_o <= wdata_i[OVR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  p_cmd_origin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_req_o |-> $past(we_i && addr_i == 2'd3 && wdata_i[0]));
endmodule

// File: rtl/sso_timer.sv
module sso_timer #(
  parameter int UNIT_CYC = 50000,
  parameter int TMR_W    = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       auto_en_i,
  input  logic [1:0] rate_i,
  input  logic [1:0] presc_i,
  output logic       tick_o
);
  localparam int M_SLOW = 10;
  localparam int M_MID  = 5;
  localparam int M_FAST = 4;

  logic [TMR_W-1:0] base, period, cnt;
  logic             active, at_end;

  always_comb begin
    unique case (rate_i)
      2'd1:    base = TMR_W'(UNIT_CYC * M_SLOW);
      2'd2:    base = TMR_W'(UNIT_CYC * M_MID);
      2'd3:    base = TMR_W'(UNIT_CYC * M_FAST);
      default: base = '0;
    endcase
    period = base << presc_i;
  end

  assign active = auto_en_i && (rate_i != 2'd0);
  assign at_end = (cnt >= period - TMR_W'(1));
  assign tick_o = active && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (!active)     cnt <= '0;
    else if (at_end)      cnt <= '0;
    else                  cnt <= cnt + TMR_W'(1);
  end

  p_no_tick_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_en_i || rate_i == 2'd0) |-> !tick_o);
endmodule

// File: rtl/sso_shifter.sv
module sso_shifter
  import sso_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [GROUPS-1:0] grp_en_i,
  input  logic              rise_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WORD_W-1:0] shadow_i,
  input  logic [OVR_W-1:0]  ovr_i,
  input  logic [OVR_W-1:0]  hw_i,
  output logic              sdo_o,
  output logic              sck_o,
  output logic              stb_o,
  output logic              busy_o
);
  sh_state_e         state;
  logic [WORD_W-1:0] sreg, merged, stream, stream_l, ovr_ext, hw_ext;
  logic [CNT_W-1:0]  nbits, left;
  logic [DIV_W-1:0]  div_q, div_cnt;
  logic              sck_int, rise_q, pend, ph, go, half;

  assign ovr_ext = {{(WORD_W-OVR_W){1'b0}}, ovr_i};
  assign hw_ext  = {{(WORD_W-OVR_W){1'b0}}, hw_i};
  assign merged  = (shadow_i & ~ovr_ext) | (hw_ext & ovr_ext);

  // pack enabled groups high-first, then left-align
  always_comb begin
    stream = '0;
    nbits  = '0;
    for (int g = GROUPS-1; g >= 0; g--) begin
      if (grp_en_i[g]) begin
        stream = {stream[WORD_W-GRP_W-1:0], merged[g*GRP_W +: GRP_W]};
        nbits  = nbits + CNT_W'(GRP_W);
      end
    end
    stream_l = stream << (CNT_W'(WORD_W) - nbits);
  end

  assign go     = (state == S_IDLE) && (req_i || pend) && (|grp_en_i);
  assign half   = (div_cnt == div_q);
  assign sdo_o  = sreg[WORD_W-1];
  assign sck_o  = sck_int ^ rise_q;
  assign stb_o  = (state == S_STROBE);
  assign busy_o = (state != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend <= 1'b0;
    else if (state == S_IDLE)   pend <= 1'b0;
    else if (req_i)             pend <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= S_IDLE;
      sreg    <= '0;
      left    <= '0;
      div_q   <= '0;
      div_cnt <= '0;
      sck_int <= 1'b0;
      rise_q  <= 1'b0;
      ph      <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (go) begin
            state   <= S_SHIFT;
            sreg    <= stream_l;
            left    <= nbits;
            div_q   <= div_i;
            div_cnt <= '0;
            sck_int <= 1'b0;
            rise_q  <= rise_i;
          end
        end
        S_SHIFT: begin
          if (half) begin
            div_cnt <= '0;
            if (!sck_int) begin
              sck_int <= 1'b1;
            end else begin
              sck_int <= 1'b0;
              if (left == CNT_W'(1)) begin
                state <= S_STROBE;
                ph    <= 1'b0;
              end else begin
                sreg <= sreg << 1;
                left <= left - CNT_W'(1);
              end
            end
          end else begin
            div_cnt <= div_cnt + DIV_W'(1);
          end
        end
        S_STROBE: begin
          if (half) begin
            div_cnt <= '0;
            if (ph) state <= S_IDLE;
            else    ph    <= 1'b1;
          end else begin
            div_cnt <= div_cnt + DIV_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_data_on_change_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != S_IDLE && $past(state != S_IDLE) && !$fell(sck_int)) |-> $stable(sdo_o));
  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_IDLE) |-> (!stb_o && !sck_int));
  p_strobe_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stb_o) |-> $fell(sck_int));
  p_hold_request_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && state != S_IDLE) |=> pend);
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left <= CNT_W'(WORD_W));
endmodule

// File: rtl/sso_ctrl.sv
module sso_ctrl
  import sso_pkg::*;
#(
  parameter int UNIT_CYC = 50000,
  parameter int TMR_W    = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic [1:0]  dsl_i,
  input  logic [11:0] phy_i,
  output logic        sdo_o,
  output logic        sck_o,
  output logic        stb_o,
  output logic        busy_o
);
  logic [WORD_W-1:0] shadow;
  logic [OVR_W-1:0]  ovr, hw;
  cfg_t              cfg;
  logic              sw_req, tmr_tick;

  assign hw = {phy_i, dsl_i};

  sso_regs u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .shadow_o (shadow),
    .cfg_o    (cfg),
    .ovr_o    (ovr),
    .sw_req_o (sw_req)
  );

  sso_timer #(.UNIT_CYC(UNIT_CYC), .TMR_W(TMR_W)) u_timer (
    .clk_i, .rst_ni,
    .auto_en_i (cfg.auto_en),
    .rate_i    (cfg.rate),
    .presc_i   (cfg.presc),
    .tick_o    (tmr_tick)
  );

  sso_shifter u_shift (
    .clk_i, .rst_ni,
    .req_i    (sw_req | tmr_tick),
    .grp_en_i (cfg.grp_en),
    .rise_i   (cfg.rise),
    .div_i    (cfg.div),
    .shadow_i (shadow),
    .ovr_i    (ovr),
    .hw_i     (hw),
    .sdo_o, .sck_o, .stb_o, .busy_o
  );

  p_sw_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_req && !busy_o && |cfg.grp_en) |=> busy_o);
  p_auto_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_tick && !busy_o && |cfg.grp_en) |=> busy_o);
  p_empty_no_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cfg.grp_en == '0) |=> !busy_o);
endmodule

// File: tb/sso_ctrl_test.sv
module sso_ctrl_test;
  localparam int UNIT = 16;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  dsl = '0;
  logic [11:0] phy = '0;
  logic        sdo, sck, stb, busy;

  sso_ctrl #(.UNIT_CYC(UNIT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .dsl_i(dsl), .phy_i(phy), .sdo_o(sdo), .sck_o(sck), .stb_o(stb), .busy_o(busy)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, ncap = 0, nrise = 0, ndone = 0, nedge = 0, viol = 0;
  int te0 = 0, te1 = 0, t_last = 0, t_prev = 0, stb_run = 0, stb_len = 0;
  logic [23:0] cap = '0;
  logic [23:0] hist [8];
  int          hn [8];
  logic        rise_mode = 1'b0;
  logic        sck_p = 1'b0, sdo_p = 1'b0, busy_p = 1'b0, stb_p = 1'b0;
  logic        done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy && !busy_p) begin
        ncap = 0; cap = '0; nedge = 0; nrise++; t_prev = t_last; t_last = cyc;
      end
      if (busy && (rise_mode ? (!sck && sck_p) : (sck && !sck_p))) begin
        if (sdo != sdo_p) viol++;
        cap = {cap[22:0], sdo};
        ncap++;
        if (nedge == 0) te0 = cyc;
        else if (nedge == 1) te1 = cyc;
        nedge++;
      end
      if (stb) stb_run++;
      if (!stb && stb_p) begin stb_len = stb_run; stb_run = 0; end
      if (stb && !stb_p) begin hist[ndone % 8] = cap; hn[ndone % 8] = ncap; ndone++; end
    end
    sck_p = sck; sdo_p = sdo; busy_p = busy; stb_p = stb;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [31:0] mk_cfg(input logic [2:0] ge, input logic rs, input logic au,
                                         input logic [1:0] rt, input logic [1:0] ps, input logic [7:0] dv);
    return {8'h00, dv, 6'h00, ps, 1'b0, rt, au, rs, ge};
  endfunction

  function automatic logic [23:0] exp_bits(input logic [23:0] sh, input logic [13:0] ov,
                                           input logic [13:0] hw, input logic [2:0] ge);
    logic [23:0] b;
    b = '0;
    for (int g = 2; g >= 0; g--)
      if (ge[g])
        for (int k = 7; k >= 0; k--) begin
          int p;
          logic v;
          p = g * 8 + k;
          v = (p < 14 && ov[p]) ? hw[p] : sh[p];
          b = {b[22:0], v};
        end
    return b;
  endfunction

  function automatic int exp_n(input logic [2:0] ge);
    return 8 * (int'(ge[0]) + int'(ge[1]) + int'(ge[2]));
  endfunction

  task automatic wait_done(input int target);
    int guard;
    guard = 0;
    while ((ndone < target || busy) && guard < 20000) begin @(negedge clk); guard++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] sh, input logic [13:0] ov, input logic [2:0] ge,
                      input logic rs, input logic [7:0] dv, input string req);
    int start;
    logic [23:0] e;
    rise_mode = rs;
    wr(2'd0, {8'h00, sh});
    wr(2'd2, {18'h0, ov});
    wr(2'd1, mk_cfg(ge, rs, 1'b0, 2'd0, 2'd0, dv));
    start = ndone;
    viol = 0;
    wr(2'd3, 32'h1);
    wait_done(start + 1);
    e = exp_bits(sh, ov, {phy, dsl}, ge);
    chk(hist[start % 8] == e && hn[start % 8] == exp_n(ge), req, hist[start % 8], e);
    chk(viol == 0, "R7 data stable at sample edge", viol, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({sck, stb, busy, sdo} == 4'b0, "R1 outputs idle after reset", {sck, stb, busy, sdo}, 0);
    repeat (400) @(negedge clk);
    chk(nrise == 0, "R1 no transfer without request", nrise, 0);
    // R1 shadow is zero after reset
    begin
      int start;
      start = ndone;
      wr(2'd1, mk_cfg(3'b111, 1'b0, 1'b0, 2'd0, 2'd0, 8'd0));
      wr(2'd3, 32'h1);
      wait_done(start + 1);
      chk(hist[start % 8] == 24'h0 && hn[start % 8] == 24, "R1 shadow reset zero", hist[start % 8], 0);
    end

    // R2 R3 group sweep
    for (int ge = 1; ge < 8; ge++) begin
      xfer(24'hA5C31E, 14'h0, 3'(ge), 1'b0, 8'd0, "R2 R3 group order");
      xfer(24'h3C96F0, 14'h0, 3'(ge), 1'b0, 8'd0, "R2 R3 group order");
    end

    // R3 no group enabled
    begin
      int r0;
      r0 = nrise;
      wr(2'd1, mk_cfg(3'b000, 1'b0, 1'b0, 2'd0, 2'd0, 8'd0));
      wr(2'd3, 32'h1);
      repeat (100) @(negedge clk);
      chk(nrise == r0 && !busy, "R3 empty request ignored", nrise - r0, 0);
    end

    // R4 overrides
    dsl = 2'b10; phy = 12'b101_011_110_001;
    xfer(24'h00FF00, 14'h3FFF, 3'b111, 1'b0, 8'd0, "R4 full override");
    xfer(24'hFFFFFF, 14'h3FFF, 3'b111, 1'b0, 8'd0, "R4 full override");
    xfer(24'h5A5A5A, 14'b10_1010_0101_0110, 3'b111, 1'b0, 8'd0, "R4 partial override");
    dsl = 2'b01; phy = 12'b010_100_001_111;
    xfer(24'h123456, 14'b11_0001_1110_0011, 3'b011, 1'b0, 8'd0, "R4 partial override");
    xfer(24'hF0F0F0, 14'h1C, 3'b001, 1'b0, 8'd0, "R4 single source");

    // R5 R6 divider and strobe width
    for (int d = 0; d < 4; d++) begin
      xfer(24'h9E37A1, 14'h0, 3'b101, 1'b0, 8'(d * 2 + 1 - (d == 0 ? 1 : 0)), "R5 divider data");
      chk(te1 - te0 == 2 * (d * 2 + 1 - (d == 0 ? 1 : 0) + 1), "R5 bit period", te1 - te0,
          2 * (d * 2 + 1 - (d == 0 ? 1 : 0) + 1));
      chk(stb_len == 2 * (d * 2 + 1 - (d == 0 ? 1 : 0) + 1), "R6 strobe width", stb_len,
          2 * (d * 2 + 1 - (d == 0 ? 1 : 0) + 1));
    end

    // R7 rising-edge mode and idle levels
    xfer(24'hC0FFEE, 14'h0, 3'b111, 1'b1, 8'd2, "R7 rising mode data");
    chk(sck == 1'b1, "R7 idle high in rising mode", sck, 1);
    xfer(24'h0BEEF1, 14'h0, 3'b110, 1'b1, 8'd0, "R7 rising mode data");
    xfer(24'h7A11CE, 14'h0, 3'b111, 1'b0, 8'd1, "R7 falling mode data");
    chk(sck == 1'b0, "R7 idle low in falling mode", sck, 0);

    // R8 request while busy is held
    begin
      int start, guard;
      rise_mode = 1'b0;
      wr(2'd2, 32'h0);
      wr(2'd0, 32'h00AB12CD);
      wr(2'd1, mk_cfg(3'b111, 1'b0, 1'b0, 2'd0, 2'd0, 8'd3));
      start = ndone;
      wr(2'd3, 32'h1);
      guard = 0;
      while (!busy && guard < 100) begin @(negedge clk); guard++; end
      chk(busy, "R8 busy during transfer", busy, 1);
      wr(2'd0, 32'h0055E077);
      wr(2'd3, 32'h1);
      wait_done(start + 2);
      chk(hist[start % 8] == 24'hAB12CD, "R8 first word", hist[start % 8], 24'hAB12CD);
      chk(hist[(start + 1) % 8] == 24'h55E077, "R8 held request runs", hist[(start + 1) % 8], 24'h55E077);
      chk(ndone == start + 2, "R8 exactly two transfers", ndone - start, 2);
    end

    // R9 automatic update periods
    for (int rt = 1; rt < 4; rt++)
      for (int ps = 0; ps < 2; ps++) begin
        int r0, guard, mult;
        mult = (rt == 1) ? 10 : (rt == 2) ? 5 : 4;
        r0 = nrise;
        wr(2'd1, mk_cfg(3'b001, 1'b0, 1'b1, 2'(rt), 2'(ps), 8'd0));
        guard = 0;
        while (nrise < r0 + 3 && guard < 5000) begin @(negedge clk); guard++; end
        chk(t_last - t_prev == (UNIT * mult) << ps, "R9 auto period", t_last - t_prev, (UNIT * mult) << ps);
        wr(2'd1, mk_cfg(3'b001, 1'b0, 1'b0, 2'(rt), 2'(ps), 8'd0));
        wait_done(0);
      end
    begin
      int r0;
      r0 = nrise;
      wr(2'd1, mk_cfg(3'b001, 1'b0, 1'b1, 2'd0, 2'd0, 8'd0));
      repeat (400) @(negedge clk);
      chk(nrise == r0, "R9 rate zero gives no updates", nrise - r0, 0);
    end
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule